// File: doc/BRIEF.md
# Bit-Alias Address Remapper

This block sits between a 32-bit bus master and a word-organised SRAM. It decodes every request against two address windows. Requests that fall in the SRAM window go straight to the memory, byte strobes included. Requests that fall in the larger alias window address one bit of one SRAM word each. A read there returns that single bit. A write there sets or clears that single bit in place.

An alias write becomes a locked read-modify-write of the target word. The block first stalls the master for one cycle while it reads the word. In the next cycle it writes the word back with only the selected bit changed. No other access can reach the memory between those two cycles. Any request that hits neither window, and any alias request whose address is not word aligned, is answered with an error and leaves the memory untouched.

The master holds a request until `req_ready` is high in the same cycle as `req_valid`. The response follows one cycle after acceptance as a single-cycle `rsp_valid` pulse. The memory is synchronous: read data appears the cycle after the read is issued.

Top module: `bitband_remap`

## Requirements
- R1: A write inside the SRAM window (base `SRAM_BASE`, 2^`SRAM_LG2` bytes) is accepted in the cycle it is presented. It performs one memory write at word index addr[SRAM_LG2-1:2], honouring the four byte strobes (strobe bit k enables byte k). It is answered one cycle later with `rsp_err`=0 and `rsp_rdata`=0.
- R2: A read inside the SRAM window is accepted at once and performs one memory read. It returns the full stored word on `rsp_rdata` one cycle later.
- R3: An alias address is ALIAS_BASE + W·128 + N·4. Its bits [6:2] give the bit index N (0 to 31). Its bits [SRAM_LG2+4:7] give the word index W. The alias window therefore spans 2^(SRAM_LG2+5) bytes.
- R4: An alias write with wdata bit 0 = 1 sets bit N of word W, and with wdata bit 0 = 0 clears it. All other bits of that word keep their value, and wdata bits 31:1 have no effect.
- R5: An alias write holds `req_ready` low in its first cycle, in which it reads word W. In the next cycle it is accepted and writes word W back. Exactly these two memory accesses occur, back to back, to the same word.
- R6: An aligned alias read performs one memory read and no write. It returns bit N of word W in `rsp_rdata` bit 0, with bits 31:1 zero.
- R7: A request outside both windows is accepted at once, makes no memory access, and is answered with `rsp_err`=1 and `rsp_rdata`=0.
- R8: An alias request with address bits [1:0] not zero is answered like R7 (error, no memory access, memory unchanged).
- R9: While reset is asserted, and in the first cycle after it, `rsp_valid` and `mem_en` are 0.
- R10: The last word of the SRAM window and bit 31 of the last alias word map correctly. The first address past either window is treated as unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte strobes for SRAM-window writes |
| req_ready | output | 1 | Request accepted this cycle |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_err | output | 1 | Request was unmapped or misaligned |
| rsp_rdata | output | 32 | Read data |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | SRAM_LG2-2 | Memory word index |
| mem_wdata | output | 32 | Memory write data |
| mem_strb | output | 4 | Memory byte enables |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read |

## Verification
The bench builds the block with `SRAM_LG2` = 8. This gives a 64-word memory and an 8 KB alias window. At that size the bench can compare the whole memory after every transaction, so a bit leaking into a neighbour is caught. It can also reach the top word, the highest alias bit and the first address past each window. Directed cases cover set and clear with the upper data bits inverted, misaligned alias addresses and holes between the windows. A few hundred pseudo-random mixed operations then follow.

// File: rtl/bitband_remap.sv
module bitband_remap #(
  parameter logic [31:0] SRAM_BASE  = 32'h2000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter int          SRAM_LG2   = 20,
  localparam int         WAW        = SRAM_LG2 - 2,
  localparam int         ALG2       = SRAM_LG2 + 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [31:0]    req_addr,
  input  logic [31:0]    req_wdata,
  input  logic [3:0]     req_strb,
  output logic           req_ready,
  output logic           rsp_valid,
  output logic           rsp_err,
  output logic [31:0]    rsp_rdata,
  output logic           mem_en,
  output logic           mem_we,
  output logic [WAW-1:0] mem_addr,
  output logic [31:0]    mem_wdata,
  output logic [3:0]     mem_strb,
  input  logic [31:0]    mem_rdata
);

  typedef enum logic [1:0] {K_WORD, K_BIT, K_ERR, K_ACK} kind_t;

  logic in_sram, in_alias, bad;
  assign in_sram  = req_addr[31:SRAM_LG2] == SRAM_BASE[31:SRAM_LG2];
  assign in_alias = req_addr[31:ALG2] == ALIAS_BASE[31:ALG2];
  assign bad      = !(in_sram || (in_alias && req_addr[1:0] == 2'b00));

  logic [WAW-1:0] sram_word, alias_word;
  logic [4:0]     alias_bit;
  assign sram_word  = req_addr[SRAM_LG2-1:2];
  assign alias_word = req_addr[ALG2-1:7];
  assign alias_bit  = req_addr[6:2];

  logic           modify;
  logic [WAW-1:0] hold_word;
  logic [4:0]     hold_bit;
  logic           hold_val;
  logic           rsp_q;
  kind_t          kind_q;
  logic [4:0]     rbit_q;

  always_comb begin
    req_ready = 1'b0;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_strb  = 4'h0;
    if (modify) begin
      req_ready = 1'b1;
      mem_en    = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = hold_word;
      mem_strb  = 4'hF;
      mem_wdata = hold_val ? (mem_rdata | (32'(1) << hold_bit))
                           : (mem_rdata & ~(32'(1) << hold_bit));
    end else if (req_valid) begin
      if (bad) begin
        req_ready = 1'b1;
      end else if (in_sram) begin
        req_ready = 1'b1;
        mem_en    = 1'b1;
        mem_we    = req_write;
        mem_addr  = sram_word;
        mem_wdata = req_wdata;
        mem_strb  = req_strb;
      end else begin
        req_ready = !req_write;
        mem_en    = 1'b1;
        mem_addr  = alias_word;
      end
    end
  end

  kind_t kind_d;
  always_comb begin
    if (bad)              kind_d = K_ERR;
    else if (req_write)   kind_d = K_ACK;
    else if (in_sram)     kind_d = K_WORD;
    else                  kind_d = K_BIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modify    <= 1'b0;
      hold_word <= '0;
      hold_bit  <= '0;
      hold_val  <= 1'b0;
      rsp_q     <= 1'b0;
      kind_q    <= K_ACK;
      rbit_q    <= '0;
    end else begin
      rsp_q <= req_valid && req_ready;
      if (req_valid && req_ready) begin
        kind_q <= kind_d;
        rbit_q <= alias_bit;
      end
      if (modify) begin
        modify <= 1'b0;
      end else if (req_valid && !bad && !in_sram && req_write) begin
        modify    <= 1'b1;
        hold_word <= alias_word;
        hold_bit  <= alias_bit;
        hold_val  <= req_wdata[0];
      end
    end
  end

  assign rsp_valid = rsp_q;
  assign rsp_err   = rsp_q && kind_q == K_ERR;
  always_comb begin
    case (kind_q)
      K_WORD:  rsp_rdata = mem_rdata;
      K_BIT:   rsp_rdata = {31'b0, mem_rdata[rbit_q]};
      default: rsp_rdata = '0;
    endcase
  end

  AST_RMW_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    modify |-> mem_en && mem_we && mem_addr == $past(mem_addr)); // R5
  AST_RMW_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    modify |-> $past(mem_en && !mem_we && !req_ready)); // R5
  AST_RMW_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && modify) |-> mem_strb == 4'hF && $countones(mem_wdata ^ mem_rdata) <= 1); // R4
  AST_ERR_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(!mem_en) && rsp_rdata == 32'h0); // R7
  AST_BIT_READ_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && kind_q == K_BIT) |-> rsp_rdata[31:1] == 31'h0); // R6
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready)); // R1

endmodule

// File: tb/sim_bitband_remap.sv
module sim_bitband_remap;
  localparam int LG2 = 8;
  localparam int WAW = LG2 - 2;
  localparam int NW  = 1 << WAW;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [3:0]  req_strb = 0;
  logic req_ready, rsp_valid, rsp_err, mem_en, mem_we;
  logic [31:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [WAW-1:0] mem_addr;
  logic [3:0] mem_strb;

  bitband_remap #(.SRAM_LG2(LG2)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_strb(mem_strb), .mem_rdata(mem_rdata));

  logic [31:0] smem [NW];
  logic [31:0] rmem [NW];
  logic [31:0] rd_q = 0;
  assign mem_rdata = rd_q;
  int acc_n = 0;
  logic [WAW-1:0] acc_addr [4];
  logic           acc_we   [4];
  always @(posedge clk) if (mem_en) begin
    if (acc_n < 4) begin acc_addr[acc_n] = mem_addr; acc_we[acc_n] = mem_we; end
    acc_n = acc_n + 1;
    if (mem_we) begin
      for (int k = 0; k < 4; k++) if (mem_strb[k]) smem[mem_addr][8*k +: 8] = mem_wdata[8*k +: 8];
    end else rd_q <= smem[mem_addr];
  end

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input bit wr, input logic [31:0] a, input logic [31:0] d, input logic [3:0] s, input string tag);
    bit isr, isa, al, err;
    int waits, exp_acc;
    logic [31:0] exp_d;
    logic [WAW-1:0] w;
    isr = a[31:LG2] == 24'h200000;
    isa = a[31:LG2+5] == (32'h2200_0000 >> (LG2+5));
    al  = a[1:0] == 2'b00;
    err = !(isr || (isa && al));
    w   = isr ? a[LG2-1:2] : a[LG2+4:7];
    exp_d   = 0;
    exp_acc = err ? 0 : ((isa && wr) ? 2 : 1);
    if (!err && !wr) exp_d = isr ? rmem[w] : {31'b0, rmem[w][a[6:2]]};
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_strb = s; acc_n = 0;
    #1;
    waits = 0;
    while (!req_ready && waits < 8) begin @(negedge clk); #1; waits++; end
    @(negedge clk);
    req_valid = 0;
    #1;
    if (!err && wr) begin
      if (isr) begin
        for (int k = 0; k < 4; k++) if (s[k]) rmem[w][8*k +: 8] = d[8*k +: 8];
      end else rmem[w][a[6:2]] = d[0];
    end
    chk(waits == ((!err && isa && wr) ? 1 : 0), {tag, " R5 stall"}, waits, (!err && isa && wr) ? 1 : 0);
    chk(rsp_valid === 1'b1, {tag, " R1 rsp_valid"}, rsp_valid, 1);
    chk(rsp_err === err, {tag, " R7 R8 err"}, rsp_err, err);
    chk(rsp_rdata === exp_d, {tag, " R2 R6 data"}, rsp_rdata, exp_d);
    chk(acc_n == exp_acc, {tag, " R7 access count"}, acc_n, exp_acc);
    if (exp_acc == 2)
      chk(!acc_we[0] && acc_we[1] && acc_addr[0] == w && acc_addr[1] == w,
          {tag, " R5 rmw order"}, {acc_addr[0], acc_addr[1]}, {w, w});
    if (exp_acc == 1)
      chk(acc_addr[0] == w && acc_we[0] == (isr && wr), {tag, " R3 word"}, acc_addr[0], w);
    for (int i = 0; i < NW; i++)
      if (smem[i] !== rmem[i]) chk(0, {tag, " R4 memory"}, smem[i], rmem[i]);
  endtask

  function automatic logic [31:0] al(input int wi, input int b);
    return 32'h2200_0000 + wi * 128 + b * 4;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    for (int i = 0; i < NW; i++) begin smem[i] = 0; rmem[i] = 0; end
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0 && mem_en === 1'b0, "R9 in reset", {rsp_valid, mem_en}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid === 1'b0 && mem_en === 1'b0, "R9 after reset", {rsp_valid, mem_en}, 0);

    op(1, 32'h2000_000C, 32'hA5A5_5A5A, 4'hF, "R1 full write");
    op(1, 32'h2000_000C, 32'h1122_3344, 4'b0101, "R1 strobed");
    op(0, 32'h2000_000C, 0, 0, "R2 read");
    op(1, al(3, 5), 32'h0000_0001, 0, "R4 set");
    op(1, al(3, 1), 32'hFFFF_FFFE, 0, "R4 clear upper ignored");
    op(1, al(3, 31), 32'hFFFF_FFFF, 0, "R4 set msb");
    op(0, al(3, 5), 0, 0, "R6 read one");
    op(0, al(3, 4), 0, 0, "R6 read zero");
    op(0, 32'h2000_000C, 0, 0, "R3 mapping");
    op(1, 32'h2000_0100, 32'hDEAD_BEEF, 4'hF, "R10 past sram");
    op(0, 32'h21FF_FFFC, 0, 0, "R7 gap");
    op(1, 32'h2200_2000, 32'h1, 0, "R10 past alias");
    op(0, 32'h0000_0000, 0, 0, "R7 low");
    op(1, 32'h2200_0181, 32'h1, 0, "R8 misaligned write");
    op(0, 32'h2200_0182, 0, 0, "R8 misaligned read");
    op(1, 32'h2000_00FC, 32'h8000_0000, 4'hF, "R10 top word");
    op(1, al(63, 31), 32'h0, 0, "R10 top bit clear");
    op(0, al(63, 31), 0, 0, "R10 top bit read");
    op(1, al(63, 0), 32'h1, 0, "R10 top bit0 set");
    op(0, 32'h2000_00FC, 0, 0, "R10 top word read");

    lf = 32'hACE1_1234;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      case (lf[3:2])
        2'd0: a = 32'h2000_0000 | {24'h0, lf[13:8], 2'b00};
        2'd1, 2'd2: a = 32'h2200_0000 | {19'h0, lf[20:8], 2'b00};
        default: a = lf[4] ? (32'h2200_0000 | {19'h0, lf[20:8], lf[6:5]}) : {lf[31:10], 10'h0};
      endcase
      op(lf[7], a, {lf[15:0], lf[31:16]}, lf[11:8], "R4 R6 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule